// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is an SPI master that a host controls through a small byte-wide register window: one address bus, one write strobe, one write-data byte and a combinational read-data byte. The host sets the frame size, bit order, serial clock rate, select mode and interrupt enable in a control register. It loads up to four data bytes and starts a frame, either with a start bit or automatically when it writes the most significant byte of the frame. It then polls a busy flag or waits for an interrupt request.

Frames are 8, 16, 24 or 32 bits long and right-aligned across the data bytes. The least significant byte always lives at the lowest data address. The bits received during a frame replace the used data bytes when the frame ends. Bytes outside the frame keep their contents. Only SPI mode 0 is produced: the serial clock idles low, the slave's bit is captured on each rising edge, and the next output bit is presented after each falling edge. Slave selects are active low. They are either driven straight from a select register or asserted by hardware on one chosen line for the length of each frame.

Top module: `spi_host_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the control, select and data registers and the done flag, stops any frame in progress, returns `sclk` to 0, drives every `ss_n` line to 1 and leaves `irq` at 0.
- R2: Control bits [1:0] (frame size code) set the number of serial clock pulses per frame: code 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32.
- R3: With control bit 4 at 0, `mosi` sends the frame from bit N-1 down to bit 0 of the right-aligned frame value. Received bits enter from the least significant end, so the first bit received becomes bit N-1.
- R4: With control bit 4 at 1, bit 0 is sent first, and the first bit received becomes bit 0 of the stored frame.
- R5: Data byte k (k = 0..3) is at address 3+k and holds frame bits 8k+7..8k. When a frame ends, bytes 0..code hold the received frame and higher bytes are unchanged.
- R6: With control bit 7 (auto start) at 1, writing address 3+code starts a frame, and writing any other data byte does not.
- R7: With auto start at 0, writing data bytes never starts a frame. Writing 1 to status bit 0 (address 1) starts one.
- R8: Status bit 0 (busy) reads 1 from the cycle after a start is accepted until the frame's last falling `sclk` edge, and reads 0 afterwards.
- R9: Control bits [3:2] set the rate code c. The `sclk` high and low phases each last 2<<(3-c) clock cycles, so code 3 is the fastest.
- R10: With control bit 5 at 0, `ss_n[s]` is 0 only while a frame is shifting, where s is bits [1:0] of the select register (address 2). All other lines stay at 1, and all lines are 1 between frames.
- R11: With control bit 5 at 1, `ss_n` equals the inverse of select register bits [3:0] at all times, whatever frames run.
- R12: Status bit 1 (done) is set when a frame ends. It is cleared by writing 1 to status bit 1 or by starting a frame. `irq` equals done AND control bit 6.
- R13: Writes to the control and data registers, and start requests, are ignored while busy reads 1.
- R14: `sclk` is 0 whenever no frame is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 4 | Active-low slave selects |
| irq | output | 1 | Frame-complete interrupt request |

## Verification
The hardest conditions to reach from the ports are host writes that land in the middle of a shifting frame, and a reset that arrives mid-frame. The stimulus starts a frame at the slowest rate, so that it lasts hundreds of cycles. It then writes the control register and a data byte outside the frame while busy still reads 1, and afterwards reads both back unchanged. A behavioural slave in the bench records each `mosi` bit on the rising edges. It drives `miso` from its own frame value, advancing on falling edges. This lets the bench check both bit orders and the right-aligned write-back for every frame size.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd3;

    // control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       auto_go;
        logic       irq_en;
        logic       manual_ss;
        logic       lsb_first;
        logic [1:0] rate;
        logic [1:0] len;
    } ctrl_t;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } sh_state_t;

    // number of bits in a frame for a size code
    function automatic logic [5:0] frame_bits(input logic [1:0] len);
        return ({4'b0000, len} + 6'd1) << 3;
    endfunction

    // clock cycles per sclk phase for a rate code
    function automatic int unsigned half_cycles(input int unsigned base,
                                                input logic [1:0] rate);
        return base << (2'd3 - rate);
    endfunction

endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen
    import spi_host_pkg::*;
#(
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int HALF_MAX = BASE_HALF << 3;
    localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = CW'(half_cycles(BASE_HALF, rate) - 1);
    assign tick = en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int NSS    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    input  logic                    sh_busy,
    input  logic                    done_pulse,
    input  logic [NBYTES*8-1:0]     rx_data,
    output ctrl_t                   cfg,
    output logic [NSS-1:0]          sel,
    output logic [NBYTES*8-1:0]     tx_data,
    output logic                    go,
    output logic                    done
);
    localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [NBYTES-1:0][7:0] data_q;
    logic                   go_q;
    logic                   busy_all;
    logic                   start;
    logic [ADDR_W-1:0]      ms_addr;
    logic [ADDR_W-1:0]      didx;
    logic                   go_req;
    logic                   auto_req;

    assign busy_all = sh_busy | go_q;
    assign ms_addr  = A_DATA + ADDR_W'(cfg.len);
    assign go_req   = wr_en && (addr == A_STAT) && wdata[0];
    assign auto_req = wr_en && cfg.auto_go && (addr == ms_addr);
    assign start    = !busy_all && (go_req || auto_req);
    assign go       = go_q;
    assign tx_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            sel  <= '0;
            go_q <= 1'b0;
            done <= 1'b0;
        end else begin
            go_q <= start;
            if (wr_en && !busy_all && addr == A_CTRL) begin
                cfg <= ctrl_t'(wdata);
            end
            if (wr_en && addr == A_SEL) begin
                sel <= wdata[NSS-1:0];
            end
            if (start) begin
                done <= 1'b0;
            end else if (done_pulse) begin
                done <= 1'b1;
            end else if (wr_en && addr == A_STAT && wdata[1]) begin
                done <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_en && !busy_all && addr == A_DATA + ADDR_W'(b)) begin
                    data_q[b] <= wdata;
                end else if (done_pulse && b <= int'(cfg.len)) begin
                    data_q[b] <= rx_data[8*b +: 8];
                end
            end
        end
    end

    assign didx = addr - A_DATA;

    always_comb begin
        rdata = 8'h00;
        if (addr == A_CTRL) begin
            rdata = cfg;
        end else if (addr == A_STAT) begin
            rdata = {6'b0, done, busy_all};
        end else if (addr == A_SEL) begin
            rdata = 8'(sel);
        end else if (addr >= A_DATA && int'(didx) < NBYTES) begin
            rdata = data_q[didx[BW-1:0]];
        end
    end

    // R13: register contents hold while a frame is pending or shifting
    a_r13_data_hold_busy: assert property (@(posedge clk) disable iff (rst)
        busy_all |=> $stable(data_q));

    // R12: end of frame from the shift engine raises the done flag
    a_r12_done_sets: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> done);

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          len,
    input  logic                lsb_first,
    input  logic [NBYTES*8-1:0] tx_data,
    input  logic                miso,
    input  logic                tick,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                done_pulse,
    output logic [NBYTES*8-1:0] rx_data
);
    localparam int FW = NBYTES * 8;
    localparam int IW = $clog2(FW);

    sh_state_t         state;
    logic [FW-1:0]     shreg;
    logic [FW-1:0]     shr_lsb;
    logic [FW-1:0]     shr_msb;
    logic [5:0]        bitcnt;
    logic [5:0]        nbits;
    logic [IW-1:0]     top_idx;
    logic              rx_bit;

    assign nbits   = frame_bits(len);
    assign top_idx = IW'(nbits - 6'd1);
    assign busy    = (state == SH_SHIFT);
    assign mosi    = lsb_first ? shreg[0] : shreg[top_idx];
    assign rx_data = shreg;
    assign shr_msb = {shreg[FW-2:0], rx_bit};

    always_comb begin
        shr_lsb          = shreg >> 1;
        shr_lsb[top_idx] = rx_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SH_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            sclk       <= 1'b0;
            rx_bit     <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg  <= tx_data;
                        bitcnt <= '0;
                        sclk   <= 1'b0;
                        state  <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk   <= 1'b1;
                            rx_bit <= miso;
                        end else begin
                            sclk  <= 1'b0;
                            shreg <= lsb_first ? shr_lsb : shr_msb;
                            if (bitcnt == nbits - 6'd1) begin
                                state      <= SH_IDLE;
                                done_pulse <= 1'b1;
                            end else begin
                                bitcnt <= bitcnt + 6'd1;
                            end
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R14: serial clock rests low outside a frame
    a_r14_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R8: an accepted start always produces a shifting frame
    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int NBYTES    = 4,
    parameter int NSS       = 4,
    parameter int BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSS-1:0]    ss_n,
    output logic              irq
);
    localparam int SW = (NSS > 1) ? $clog2(NSS) : 1;

    ctrl_t                cfg;
    logic [NSS-1:0]       sel;
    logic [NBYTES*8-1:0]  tx_data;
    logic [NBYTES*8-1:0]  rx_data;
    logic                 go;
    logic                 done;
    logic                 busy;
    logic                 done_pulse;
    logic                 tick;

    spi_host_regs #(.NBYTES(NBYTES), .NSS(NSS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .sh_busy    (busy),
        .done_pulse (done_pulse),
        .rx_data    (rx_data),
        .cfg        (cfg),
        .sel        (sel),
        .tx_data    (tx_data),
        .go         (go),
        .done       (done)
    );

    spi_host_clkgen #(.BASE_HALF(BASE_HALF)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .en   (busy),
        .rate (cfg.rate),
        .tick (tick)
    );

    spi_host_shifter #(.NBYTES(NBYTES)) u_sh (
        .clk        (clk),
        .rst        (rst),
        .start      (go),
        .len        (cfg.len),
        .lsb_first  (cfg.lsb_first),
        .tx_data    (tx_data),
        .miso       (miso),
        .tick       (tick),
        .sclk       (sclk),
        .mosi       (mosi),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_data    (rx_data)
    );

    for (genvar i = 0; i < NSS; i++) begin : g_ss
        assign ss_n[i] = cfg.manual_ss ? ~sel[i]
                                       : ~(busy && sel[SW-1:0] == SW'(i));
    end

    assign irq = done & cfg.irq_en;

    // R10: hardware select never asserts more than one line
    a_r10_one_line: assert property (@(posedge clk) disable iff (rst)
        !cfg.manual_ss |-> $onehot0(~ss_n));

endmodule

// File: tb/sim_spi_host_ctrl.sv
`timescale 1ns/1ps
module sim_spi_host_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sclk, mosi, miso;
    logic [3:0] ss_n;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    // slave model state
    logic [31:0] s_tx  = '0;
    int          s_n   = 8;
    bit          s_lsb = 1'b0;
    int          idx   = 0;
    int          rises = 0;
    int          falls = 0;
    logic [31:0] got   = '0;
    realtime     t_r, t_f;
    int          mk;

    spi_host_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_n(ss_n), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always_comb begin
        mk   = s_lsb ? idx : (s_n - 1 - idx);
        miso = (mk >= 0 && mk < 32) ? s_tx[mk] : 1'b0;
    end

    always @(posedge sclk) begin
        if (rises == 0) t_r = $realtime;
        if (s_lsb) begin
            if (rises < 32) got[rises] = mosi;
        end else begin
            got = {got[30:0], mosi};
        end
        rises++;
    end

    always @(negedge sclk) begin
        if (falls == 0) t_f = $realtime;
        falls++;
        idx++;
    end

    // stimulus: {size[68:67], rate[66:65], lsb[64], master tx[63:32], slave tx[31:0]}
    localparam logic [68:0] VEC [6] = '{
        {2'd0, 2'd3, 1'b0, 32'h000000A5, 32'h0000003C},
        {2'd1, 2'd3, 1'b1, 32'h00001234, 32'h0000BEEF},
        {2'd2, 2'd2, 1'b0, 32'h00C0FFEE, 32'h00135799},
        {2'd3, 2'd3, 1'b0, 32'hDEADBEEF, 32'h87654321},
        {2'd3, 2'd1, 1'b1, 32'h0F1E2D3C, 32'hA5C3E1F0},
        {2'd2, 2'd3, 1'b1, 32'h00ABCDEF, 32'h00765432}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int k = 0; k < 5000; k++) begin
            rd(3'd1, st);
            if (!st[0]) break;
        end
    endtask

    task automatic slave_arm(input logic [31:0] tx, input int n, input bit lsb);
        s_tx = tx; s_n = n; s_lsb = lsb;
        idx = 0; rises = 0; falls = 0; got = '0;
    endtask

    initial begin
        logic [7:0]  r;
        logic [31:0] mask;

        repeat (3) @(negedge clk);
        // R1: reset state
        rd(3'd0, r); chk(r == 8'h00, "R1 ctrl", r, 0);
        rd(3'd1, r); chk(r == 8'h00, "R1 status", r, 0);
        chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            logic [68:0] v;
            logic [1:0]  len, rate;
            bit          lsb, auto;
            logic [31:0] tx, srx;
            int          nb;
            logic [1:0]  s;
            v = VEC[i];
            len = v[68:67]; rate = v[66:65]; lsb = v[64];
            tx = v[63:32]; srx = v[31:0];
            nb = int'(len) + 1;
            auto = (i % 2 == 0);
            s = 2'(i % 4);
            mask = (nb == 4) ? 32'hFFFFFFFF : ((32'h1 << (nb * 8)) - 1);

            wr(3'd0, 8'h00);
            for (int b = 0; b < 4; b++) wr(3'(3 + b), 8'h77);
            wr(3'd2, {6'b0, s});
            wr(3'd0, {auto, 1'b0, 1'b0, lsb, rate, len});
            slave_arm(srx, nb * 8, lsb);

            for (int b = 0; b < nb - 1; b++) wr(3'(3 + b), tx[8*b +: 8]);
            rd(3'd1, r);
            chk(r[0] == 1'b0, auto ? "R6 low byte no start" : "R7 data no start", r, 0);
            wr(3'(3 + nb - 1), tx[8*(nb-1) +: 8]);
            if (!auto) begin
                rd(3'd1, r);
                chk(r[0] == 1'b0, "R7 ms byte no start", r, 0);
                wr(3'd1, 8'h01);
            end
            rd(3'd1, r);
            chk(r[0] == 1'b1, auto ? "R6 ms byte start / R8 busy" : "R7 go / R8 busy", r, 1);
            repeat (3) @(negedge clk);
            chk(ss_n == ~(4'b0001 << s), "R10 selected line", ss_n, ~(4'b0001 << s));

            wait_idle();
            chk(rises == nb * 8, "R2 pulse count", rises, nb * 8);
            chk(got == (tx & mask), lsb ? "R4 lsb-first tx" : "R3 msb-first tx", got, tx & mask);
            chk(int'((t_f - t_r) / 8.0) == (2 << (3 - int'(rate))), "R9 phase length",
                int'((t_f - t_r) / 8.0), 2 << (3 - int'(rate)));
            for (int b = 0; b < 4; b++) begin
                rd(3'(3 + b), r);
                if (b < nb)
                    chk(r == srx[8*b +: 8], lsb ? "R4/R5 rx byte" : "R3/R5 rx byte", r, srx[8*b +: 8]);
                else
                    chk(r == 8'h77, "R5 unused byte kept", r, 8'h77);
            end
            chk(ss_n == 4'hF, "R10 released", ss_n, 4'hF);
            chk(sclk == 1'b0, "R14 sclk idle", sclk, 0);
            chk(irq == 1'b0, "R12 irq disabled", irq, 0);
            rd(3'd1, r);
            chk(r == 8'h02, "R12 done flag / R8 idle", r, 8'h02);
        end

        // R13: writes during a slow frame are ignored
        wr(3'd0, 8'h00);
        wr(3'd6, 8'h11);
        wr(3'd2, 8'h00);
        slave_arm(32'h0, 8, 1'b0);
        wr(3'd0, 8'h40);           // size 8, slowest rate, irq enabled
        wr(3'd1, 8'h01);
        rd(3'd1, r);
        chk(r[0] == 1'b1, "R8 busy slow", r, 1);
        wr(3'd6, 8'h99);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h01);
        wait_idle();
        rd(3'd6, r); chk(r == 8'h11, "R13 data write ignored", r, 8'h11);
        rd(3'd0, r); chk(r == 8'h40, "R13 ctrl write ignored", r, 8'h40);
        chk(falls == 8, "R13 no restart while busy", falls, 8);
        // R12: irq raised, then cleared
        chk(irq == 1'b1, "R12 irq set", irq, 1);
        wr(3'd1, 8'h02);
        @(negedge clk);
        chk(irq == 1'b0, "R12 irq cleared", irq, 0);
        rd(3'd1, r); chk(r == 8'h00, "R12 done cleared", r, 0);

        // R11: manual selects follow the register through a frame
        wr(3'd0, 8'h2C);           // manual, rate 3, size 8
        wr(3'd2, 8'h05);
        @(negedge clk);
        chk(ss_n == 4'b1010, "R11 manual idle", ss_n, 4'b1010);
        slave_arm(32'h0, 8, 1'b0);
        wr(3'd1, 8'h01);
        repeat (4) @(negedge clk);
        chk(ss_n == 4'b1010, "R11 manual during frame", ss_n, 4'b1010);
        wait_idle();
        wr(3'd2, 8'h0C);
        @(negedge clk);
        chk(ss_n == 4'b0011, "R11 manual update", ss_n, 4'b0011);

        // R1: reset in the middle of a frame
        wr(3'd0, 8'h03);           // hardware select, slowest rate, 32 bits
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h01);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(ss_n == 4'hF, "R1 mid-frame ss_n", ss_n, 4'hF);
        chk(sclk == 1'b0, "R1 mid-frame sclk", sclk, 0);
        rd(3'd1, r); chk(r == 8'h00, "R1 mid-frame status", r, 0);
        rd(3'd3, r); chk(r == 8'h00, "R1 data cleared", r, 0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule